// File: doc/BRIEF.md
# VLIW Molecule Dispatch Unit

This block sits between an instruction fetch buffer and five execution units of a very long instruction word core. It takes one long instruction word (a molecule) at a time over a valid/ready handshake, holds it in a single register, splits it into 32-bit sub-operations (atoms) and hands each atom to a fixed unit port: integer unit 0, integer unit 1, the floating-point unit, the load/store unit and the branch unit. The molecule's header alone decides the routing. No atom opcode is inspected, no dependency is checked and nothing is reordered.

A molecule is either a short form of 64 bits with two atom slots or a long form of 128 bits with four slots. Every atom of a molecule leaves in the same cycle, and molecules leave in the order they were accepted. A stall from any unit freezes the whole molecule. Nothing issues until every unit is free. Units that get no atom from the current molecule see their valid low, which counts as a no-op.

Top module: `molecule_dispatch`

## Requirements
- R1: A synchronous active-high reset empties the molecule register. In the cycle after reset, every unit valid is low and `in_ready` is high.
- R2: Bit 0 of atom 0 (`in_mol[0]`) is the length flag. With 0 the molecule is short and issues exactly two atoms, from slots 0 and 1. With 1 it is long and issues exactly four atoms, from slots 0 to 3. Slot k is `in_mol[32k+31:32k]`.
- R3: Bits 2:1 of atom 0 form the format code. It maps slots 0,1,2,3 to units as follows. Code 0 maps them to INT0, INT1, LSU, BR. Code 1 maps them to INT0, FPU, LSU, BR. Code 2 maps them to INT0, INT1, FPU, LSU. Code 3 maps them to FPU, INT0, BR, INT1. Unit port indices are INT0=0, INT1=1, FPU=2, LSU=3, BR=4. Each atom reaches its unit unchanged, header bits included.
- R4: A unit that receives no atom from the issuing molecule has its valid low.
- R5: For a short molecule, `in_mol[127:64]` has no effect on any unit port.
- R6: A molecule accepted at a clock edge shows on the unit ports in the following cycle. All of its atoms have their valids high together in that single cycle.
- R7: While any bit of `unit_stall` is high, all unit valids are low and `in_ready` is low if a molecule is held. The held molecule stays unchanged and issues complete once the stall clears.
- R8: Each accepted molecule issues exactly once, and molecules issue in acceptance order.
- R9: `in_ready` is high whenever no molecule is held, or the held molecule is issuing in this cycle. This lets one molecule per cycle flow through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch side presents a molecule |
| in_ready | output | 1 | Block accepts the molecule at this edge |
| in_mol | input | 128 | Molecule; slot k in bits 32k+31:32k, header in bits 2:0 |
| unit_stall | input | 5 | Per-unit stall, indexed INT0, INT1, FPU, LSU, BR |
| u_valid | output | 5 | Per-unit atom valid, same indexing |
| u_atom | output | 5x32 | Per-unit atom bus, packed, unit index major |

## Verification
A molecule taken at a rising edge has its atoms on the unit ports throughout the next cycle, or throughout the first later cycle with no stall. Stall acts combinationally on the valids and on `in_ready` within the same cycle. The bench therefore drives each cycle's inputs just after the falling edge and compares the ports one nanosecond later against a model. At the following rising edge it advances that model's held-molecule state with the handshake it drove. The expected routing comes from an inverse unit-to-slot table in the bench, and the long-random phase mixes formats, lengths, garbage in the upper half and stalls.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;

  localparam int ATOM_W    = 32;
  localparam int SLOTS     = 4;
  localparam int UNITS     = 5;
  localparam int SLOT_IDXW = $clog2(SLOTS);
  localparam int MOL_W     = ATOM_W * SLOTS;

  typedef enum logic [2:0] {
    U_INT0 = 3'd0,
    U_INT1 = 3'd1,
    U_FPU  = 3'd2,
    U_LSU  = 3'd3,
    U_BR   = 3'd4
  } unit_e;

  // Fixed slot-to-unit maps selected by the 2-bit format code.
  function automatic unit_e slot_unit(input logic [1:0] fmt, input logic [1:0] slot);
    unit_e u;
    unique case ({fmt, slot})
      4'b00_00: u = U_INT0;
      4'b00_01: u = U_INT1;
      4'b00_10: u = U_LSU;
      4'b00_11: u = U_BR;
      4'b01_00: u = U_INT0;
      4'b01_01: u = U_FPU;
      4'b01_10: u = U_LSU;
      4'b01_11: u = U_BR;
      4'b10_00: u = U_INT0;
      4'b10_01: u = U_INT1;
      4'b10_10: u = U_FPU;
      4'b10_11: u = U_LSU;
      4'b11_00: u = U_FPU;
      4'b11_01: u = U_INT0;
      4'b11_10: u = U_BR;
      default:  u = U_INT1;
    endcase
    return u;
  endfunction

  // Slot is live for the molecule length: short form uses the lower half only.
  function automatic logic slot_live(input logic long_form, input int unsigned slot);
    return long_form || (slot < SLOTS / 2);
  endfunction

endpackage

// File: rtl/mdisp_hold.sv
module mdisp_hold #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         drain,
  input  logic [W-1:0] d,
  output logic         held,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
      q    <= '0;
    end else begin
      if (load) begin
        held <= 1'b1;
        q    <= d;
      end else if (drain) begin
        held <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mdisp_decode.sv
module mdisp_decode
  import mdisp_pkg::*;
(
  input  logic [2:0]       hdr,
  output logic             long_form,
  output logic [1:0]       fmt,
  output logic [SLOTS-1:0] slot_act
);

  assign long_form = hdr[0];
  assign fmt       = hdr[2:1];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_act[s] = slot_live(long_form, s);
  end

endmodule

// File: rtl/mdisp_route.sv
module mdisp_route
  import mdisp_pkg::*;
#(
  parameter int AW = ATOM_W
) (
  input  logic [SLOTS-1:0][AW-1:0] slot_atom,
  input  logic [1:0]               fmt,
  input  logic [SLOTS-1:0]         slot_act,
  input  logic                     issue_en,
  output logic [UNITS-1:0]         u_valid,
  output logic [UNITS-1:0][AW-1:0] u_atom
);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    always_comb begin
      u_valid[u] = 1'b0;
      u_atom[u]  = '0;
      for (int s = 0; s < SLOTS; s++) begin
        if (slot_act[s] && (slot_unit(fmt, SLOT_IDXW'(s)) == unit_e'(u))) begin
          u_valid[u] = issue_en;
          u_atom[u]  = slot_atom[s];
        end
      end
    end
  end

endmodule

// File: rtl/molecule_dispatch.sv
module molecule_dispatch
  import mdisp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [MOL_W-1:0]             in_mol,
  input  logic [UNITS-1:0]             unit_stall,
  output logic [UNITS-1:0]             u_valid,
  output logic [UNITS-1:0][ATOM_W-1:0] u_atom
);

  logic             stall_any;
  logic             held;
  logic [MOL_W-1:0] held_mol;
  logic             accept_fire;
  logic             issue_fire;
  logic             long_form;
  logic [1:0]       fmt;
  logic [SLOTS-1:0] slot_act;
  logic [SLOTS-1:0][ATOM_W-1:0] slot_atom;

  assign stall_any   = |unit_stall;
  assign issue_fire  = held && !stall_any;
  assign in_ready    = !held || !stall_any;
  assign accept_fire = in_valid && in_ready;
  assign slot_atom   = held_mol;

  mdisp_hold #(.W(MOL_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .load  (accept_fire),
    .drain (issue_fire),
    .d     (in_mol),
    .held  (held),
    .q     (held_mol)
  );

  mdisp_decode u_dec (
    .hdr       (held_mol[2:0]),
    .long_form (long_form),
    .fmt       (fmt),
    .slot_act  (slot_act)
  );

  mdisp_route #(.AW(ATOM_W)) u_route (
    .slot_atom (slot_atom),
    .fmt       (fmt),
    .slot_act  (slot_act),
    .issue_en  (issue_fire),
    .u_valid   (u_valid),
    .u_atom    (u_atom)
  );

endmodule

// File: rtl/mdisp_checker.sv
module mdisp_checker
  import mdisp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [UNITS-1:0] unit_stall,
  input logic [UNITS-1:0] u_valid,
  input logic             held,
  input logic             long_form,
  input logic             issue_fire,
  input logic [MOL_W-1:0] held_mol
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (u_valid == '0 && in_ready));

  a_r2_short_two: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && !long_form) |-> ($countones(u_valid) == 2));

  a_r2_long_four: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && long_form) |-> ($countones(u_valid) == 4));

  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (|unit_stall) |-> (u_valid == '0));

  a_r7_ready_low: assert property (@(posedge clk) disable iff (rst)
    (held && |unit_stall) |-> !in_ready);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (held && |unit_stall) |=> (held && $stable(held_mol)));

  a_r8_single_issue: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && !in_valid) |=> !held);

  a_r9_ready_free: assert property (@(posedge clk) disable iff (rst)
    !held |-> in_ready);

endmodule

bind molecule_dispatch mdisp_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .unit_stall (unit_stall),
  .u_valid    (u_valid),
  .held       (held),
  .long_form  (long_form),
  .issue_fire (issue_fire),
  .held_mol   (held_mol)
);

// File: tb/tb_molecule_dispatch.sv
`timescale 1ns/1ps
module tb_molecule_dispatch;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic             in_ready;
  logic [127:0]     in_mol;
  logic [4:0]       unit_stall;
  logic [4:0]       u_valid;
  logic [4:0][31:0] u_atom;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the held molecule.
  bit           m_held = 1'b0;
  logic [127:0] m_mol  = '0;

  always #2 clk = ~clk;

  molecule_dispatch dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mol(in_mol), .unit_stall(unit_stall), .u_valid(u_valid), .u_atom(u_atom)
  );

  // Inverse map (R3): which slot feeds unit u for format f, or -1.
  function automatic int unit_slot(input int f, input int u);
    int t [4][5] = '{
      '{0, 1, -1, 2, 3},
      '{0, -1, 1, 2, 3},
      '{0, 1, 2, 3, -1},
      '{1, 3, 0, -1, 2}};
    return t[f][u];
  endfunction

  function automatic logic [127:0] mk_mol(input int f, input bit lng);
    logic [127:0] m;
    m = {$urandom, $urandom, $urandom, $urandom};
    m[2:0] = {f[1:0], lng};
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle, compare the ports mid-cycle, advance the model at the edge.
  task automatic step(input bit v, input logic [127:0] mol, input logic [4:0] st);
    bit   e_rdy;
    logic [4:0] e_val;
    int   f, sl;
    @(negedge clk);
    in_valid = v; in_mol = mol; unit_stall = st;
    #1;
    e_rdy = !m_held || (st == 0);
    check(in_ready === e_rdy, "R7/R9", "in_ready", 64'(in_ready), 64'(e_rdy));
    f = int'(m_mol[2:1]);
    e_val = '0;
    for (int u = 0; u < 5; u++) begin
      sl = unit_slot(f, u);
      if (m_held && st == 0 && sl >= 0 && (m_mol[0] || sl < 2)) begin
        e_val[u] = 1'b1;
        check(u_atom[u] === m_mol[sl*32 +: 32], "R3/R5/R8", "u_atom",
              64'(u_atom[u]), 64'(m_mol[sl*32 +: 32]));
      end
    end
    check(u_valid === e_val, "R2/R4/R6/R7", "u_valid", 64'(u_valid), 64'(e_val));
    @(posedge clk);
    if (m_held && st == 0) m_held = 1'b0;
    if (v && e_rdy) begin m_held = 1'b1; m_mol = mol; end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] m;
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; in_valid = 1'b0; in_mol = '0; unit_stall = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: ports clear right after reset.
    check(u_valid === 5'b0, "R1", "u_valid after reset", 64'(u_valid), 64'h0);
    check(in_ready === 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'h1);

    // R3/R2: each format in both lengths, back to back (R9 flow).
    for (int f = 0; f < 4; f++)
      for (int l = 0; l < 2; l++) step(1'b1, mk_mol(f, l[0]), '0);
    step(1'b0, '0, '0);

    // R5: short molecule with all-ones upper half, then same with zeros.
    m = mk_mol(3, 1'b0); m[127:64] = '1;
    step(1'b1, m, '0);
    m[127:64] = '0;
    step(1'b1, m, '0);
    step(1'b0, '0, '0);

    // R7: stall holds a molecule for several cycles, new input waits (R8).
    step(1'b1, mk_mol(1, 1'b1), '0);
    step(1'b1, mk_mol(2, 1'b1), 5'b00100);
    step(1'b1, mk_mol(2, 1'b1), 5'b10000);
    step(1'b1, mk_mol(0, 1'b0), 5'b11111);
    step(1'b1, mk_mol(0, 1'b0), '0);
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);

    // Random phase.
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] st;
      st = ($urandom_range(3) == 0) ? 5'(1 << $urandom_range(4)) : 5'b0;
      step($urandom_range(4) != 0, mk_mol($urandom_range(3), $urandom_range(1) == 1), st);
    end
    step(1'b0, '0, '0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule